// File: doc/BRIEF.md
# Transmit PCM Gain and Companding Formatter

This block sits between a transmit A/D path and a time-slot serial port. Each linear 16-bit sample is scaled by a digital gain. An 8-bit gain code selects that gain, spanning roughly 12 dB in steps finer than 0.1 dB. The scaled sample is then encoded as A-law, μ-law or 16-bit linear PCM. The result is held until it is sent one byte per time-slot strobe. A gain code of zero mutes the channel, and the held code is then the idle pattern of the active law. In linear mode, one sample fills two consecutive slots.

The gain code, the law and the linear option come from configuration inputs. The alternative is strap mode, where two pins set the channel. One pin selects one of two fixed gain codes and the other picks the law. Linear coding is not available in strap mode. Settings are captured together with each sample, so later changes do not alter a held code.

Top module: `tx_pcm_fmt`

## Requirements
- R1: While rst_ni is low, and after its release until the first slot strobe, pcm_o is 0x00 and pcm_valid_o is 0.
- R2: For gain code c in 1..255 the factor is (1036 + 12*c)/4096, and the scaled sample is floor(sample*factor/4096·4096)/… expressed exactly as floor(sample*(1036+12*c)/4096). Code 0xFF is exactly unity gain.
- R3: A gain code of 0x00 makes the held code the idle pattern: 0xFF for μ-law, 0xD5 for A-law, 0x0000 for linear.
- R4: With cfg_linear_i low, cfg_alaw_i high selects A-law and low selects μ-law. cfg_linear_i high selects 16-bit linear and overrides the law bit.
- R5: μ-law takes the magnitude of the scaled sample, clips it to 32635 and adds a bias of 132. The exponent e (0..7) is the position of the highest set bit among bits 14..7, minus 7. The mantissa is bits e+6..e+3. The code sent is the bitwise inverse of {sign(1 = negative), e, mantissa}.
- R6: A-law shifts the scaled sample arithmetically right by 3. A negative value v becomes -v-1. The segment s is 0 below 32; otherwise it is the highest set bit position minus 4. The mantissa is bits 4..1 for s<2 and bits s+3..s otherwise. The code is {sign(1 = non-negative), s, mantissa} XOR 0x55.
- R7: In linear mode, the first slot after a sample carries bits 15..8 and the next carries bits 7..0. Further slots keep alternating, and a new sample restarts at the high byte.
- R8: In A-law or μ-law mode, every slot strobe sends the same held 8-bit code until a new sample is loaded.
- R9: In strap mode, strap_gain_i high applies gain code 0xFF and low applies 0x8F. cfg_gain_i has no effect.
- R10: In strap mode, strap_alaw_i high selects A-law and low selects μ-law. cfg_alaw_i and cfg_linear_i have no effect.
- R11: pcm_valid_o is high exactly in the cycle after a cycle with slot_i high, and pcm_o carries that slot's byte there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sample_valid_i | input | 1 | Loads a new sample with the current settings |
| sample_i | input | 16 | Signed linear sample from the A/D path |
| slot_i | input | 1 | Time-slot strobe requesting one output byte |
| strap_mode_i | input | 1 | 1 = settings from strap pins, 0 = from configuration inputs |
| cfg_gain_i | input | 8 | Configured gain code, 0x00 mutes |
| cfg_alaw_i | input | 1 | Configured law: 1 A-law, 0 μ-law |
| cfg_linear_i | input | 1 | Configured 16-bit linear coding |
| strap_gain_i | input | 1 | Strap gain pin: 1 code 0xFF, 0 code 0x8F |
| strap_alaw_i | input | 1 | Strap law pin: 1 A-law, 0 μ-law |
| pcm_o | output | 8 | PCM byte for the current slot |
| pcm_valid_o | output | 1 | pcm_o holds a slot byte this cycle |

## Verification
The hardest case to reach is the linear byte order once it falls out of step with the sample rate. This happens when a third slot arrives before the next sample, or when a new sample lands after only one of its predecessor's two slots. The stimulus reaches both cases directly. It strobes three slots after one linear sample, then loads a fresh sample after a single slot and checks that the next byte is again the high byte. Segment boundaries of both laws are reached by driving full-scale positive and negative samples through unity and reduced gain codes.

// File: rtl/tx_pcm_pkg.sv
package tx_pcm_pkg;
  localparam int SMP_W     = 16;
  localparam int GAIN_W    = 8;
  localparam int FRAC_W    = 12;
  localparam int GAIN_BASE = 1036;
  localparam int GAIN_STEP = 12;
  localparam int BYTE_W    = 8;
  localparam logic [GAIN_W-1:0] STRAP_GAIN_HI = 8'hFF;
  localparam logic [GAIN_W-1:0] STRAP_GAIN_LO = 8'h8F;

  typedef enum logic [1:0] {LAW_MU, LAW_A, LAW_LIN} law_e;
endpackage

// File: rtl/tx_gain_scale.sv
module tx_gain_scale
  import tx_pcm_pkg::*;
(
  input  logic [GAIN_W-1:0]       code_i,
  input  logic signed [SMP_W-1:0] smp_i,
  output logic signed [SMP_W-1:0] smp_o
);
  localparam int FACT_W = FRAC_W + 1;
  localparam int PROD_W = SMP_W + FACT_W + 1;

  logic [FACT_W-1:0]        factor;
  logic signed [PROD_W-1:0] smp_x, fac_x, prod;

  always_comb begin
    factor = FACT_W'(GAIN_BASE + GAIN_STEP * int'(code_i));
    smp_x  = PROD_W'(smp_i);
    fac_x  = PROD_W'({1'b0, factor});
    prod   = smp_x * fac_x;
    // factor never exceeds unity, so the result always fits
    smp_o  = (code_i == '0) ? '0 : SMP_W'(prod >>> FRAC_W);
  end
endmodule

// File: rtl/tx_law_enc.sv
module tx_law_enc
  import tx_pcm_pkg::*;
(
  input  law_e                    law_i,
  input  logic signed [SMP_W-1:0] smp_i,
  output logic [SMP_W-1:0]        word_o
);
  logic              mu_sign;
  logic [SMP_W-1:0]  mu_mag, mu_biased, mu_shift;
  logic [2:0]        mu_exp;
  logic [BYTE_W-1:0] mu_code;

  always_comb begin
    mu_sign = smp_i[SMP_W-1];
    mu_mag  = mu_sign ? SMP_W'(-smp_i) : SMP_W'(smp_i);
    if (mu_mag > 16'd32635) mu_mag = 16'd32635;
    mu_biased = mu_mag + 16'd132;
    mu_exp = '0;
    for (int i = 0; i < 8; i++)
      if (mu_biased[i+7]) mu_exp = 3'(i);
    mu_shift = mu_biased >> (4'(mu_exp) + 4'd3);
    mu_code  = ~{mu_sign, mu_exp, mu_shift[3:0]};
  end

  logic [12:0]       a_t;
  logic              a_pos;
  logic [11:0]       a_m, a_sh;
  logic [2:0]        a_seg;
  logic [BYTE_W-1:0] a_code;

  always_comb begin
    a_t   = smp_i[SMP_W-1:3];
    a_pos = !a_t[12];
    a_m   = a_pos ? a_t[11:0] : ~a_t[11:0];
    a_seg = '0;
    for (int i = 5; i < 12; i++)
      if (a_m[i]) a_seg = 3'(i - 4);
    a_sh   = (a_seg < 3'd2) ? (a_m >> 1) : (a_m >> a_seg);
    a_code = {a_pos, a_seg, a_sh[3:0]} ^ 8'h55;
  end

  always_comb begin
    unique case (law_i)
      LAW_A:   word_o = {8'h00, a_code};
      LAW_LIN: word_o = smp_i;
      default: word_o = {8'h00, mu_code};
    endcase
  end
endmodule

// File: rtl/tx_slot_ser.sv
module tx_slot_ser
  import tx_pcm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SMP_W-1:0]  word_i,
  input  logic              lin_i,
  input  logic              slot_i,
  output logic [SMP_W-1:0]  word_o,
  output logic              lin_o,
  output logic              sel_o,
  output logic [BYTE_W-1:0] pcm_o,
  output logic              pcm_valid_o
);
  logic [SMP_W-1:0] word_q;
  logic             lin_q, sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q      <= '0;
      lin_q       <= 1'b0;
      sel_q       <= 1'b0;
      pcm_o       <= '0;
      pcm_valid_o <= 1'b0;
    end else begin
      pcm_valid_o <= slot_i;
      if (slot_i) begin
        pcm_o <= (lin_q && !sel_q) ? word_q[SMP_W-1:BYTE_W] : word_q[BYTE_W-1:0];
        if (lin_q) sel_q <= !sel_q;
      end
      // a new sample always restarts at the high byte
      if (load_i) begin
        word_q <= word_i;
        lin_q  <= lin_i;
        sel_q  <= 1'b0;
      end
    end
  end

  assign word_o = word_q;
  assign lin_o  = lin_q;
  assign sel_o  = sel_q;
endmodule

// File: rtl/tx_pcm_fmt.sv
module tx_pcm_fmt
  import tx_pcm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_valid_i,
  input  logic [SMP_W-1:0]  sample_i,
  input  logic              slot_i,
  input  logic              strap_mode_i,
  input  logic [GAIN_W-1:0] cfg_gain_i,
  input  logic              cfg_alaw_i,
  input  logic              cfg_linear_i,
  input  logic              strap_gain_i,
  input  logic              strap_alaw_i,
  output logic [BYTE_W-1:0] pcm_o,
  output logic              pcm_valid_o
);
  logic [GAIN_W-1:0]       eff_gain;
  logic                    eff_alaw, eff_linear;
  law_e                    eff_law;
  logic signed [SMP_W-1:0] scaled;
  logic [SMP_W-1:0]        enc_word, held_word;
  logic                    held_lin, byte_sel;

  always_comb begin
    if (strap_mode_i) begin
      eff_gain   = strap_gain_i ? STRAP_GAIN_HI : STRAP_GAIN_LO;
      eff_alaw   = strap_alaw_i;
      eff_linear = 1'b0;
    end else begin
      eff_gain   = cfg_gain_i;
      eff_alaw   = cfg_alaw_i;
      eff_linear = cfg_linear_i;
    end
    eff_law = eff_linear ? LAW_LIN : (eff_alaw ? LAW_A : LAW_MU);
  end

  tx_gain_scale u_gain (
    .code_i (eff_gain),
    .smp_i  ($signed(sample_i)),
    .smp_o  (scaled)
  );

  tx_law_enc u_enc (
    .law_i  (eff_law),
    .smp_i  (scaled),
    .word_o (enc_word)
  );

  tx_slot_ser u_ser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (sample_valid_i),
    .word_i      (enc_word),
    .lin_i       (eff_linear),
    .slot_i      (slot_i),
    .word_o      (held_word),
    .lin_o       (held_lin),
    .sel_o       (byte_sel),
    .pcm_o       (pcm_o),
    .pcm_valid_o (pcm_valid_o)
  );
endmodule

// File: rtl/tx_pcm_fmt_chk.sv
module tx_pcm_fmt_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sample_valid_i,
  input logic [15:0] sample_i,
  input logic        slot_i,
  input logic        strap_mode_i,
  input logic [7:0]  eff_gain,
  input logic        eff_alaw,
  input logic        eff_linear,
  input logic [15:0] held_word,
  input logic        held_lin,
  input logic        byte_sel,
  input logic [7:0]  pcm_o,
  input logic        pcm_valid_o
);
  a_r11_slot_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_i |=> pcm_valid_o);

  a_r11_no_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_i |=> !pcm_valid_o);

  a_r3_mute_alaw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && eff_gain == 8'h00 && eff_alaw && !eff_linear) |=> held_word[7:0] == 8'hD5);

  a_r3_mute_ulaw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && eff_gain == 8'h00 && !eff_alaw && !eff_linear) |=> held_word[7:0] == 8'hFF);

  a_r2_unity_linear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && eff_gain == 8'hFF && eff_linear) |=> held_word == $past(sample_i));

  a_r7_msb_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i && !sample_valid_i && held_lin && !byte_sel) |=> pcm_o == $past(held_word[15:8]));

  a_r10_strap_no_linear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && strap_mode_i) |=> !held_lin);
endmodule

bind tx_pcm_fmt tx_pcm_fmt_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sample_valid_i (sample_valid_i),
  .sample_i       (sample_i),
  .slot_i         (slot_i),
  .strap_mode_i   (strap_mode_i),
  .eff_gain       (eff_gain),
  .eff_alaw       (eff_alaw),
  .eff_linear     (eff_linear),
  .held_word      (held_word),
  .held_lin       (held_lin),
  .byte_sel       (byte_sel),
  .pcm_o          (pcm_o),
  .pcm_valid_o    (pcm_valid_o)
);

// File: tb/tx_pcm_fmt_tb.sv
module tx_pcm_fmt_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sample_valid_i = 1'b0;
  logic [15:0] sample_i = '0;
  logic        slot_i = 1'b0;
  logic        strap_mode_i = 1'b0;
  logic [7:0]  cfg_gain_i = '0;
  logic        cfg_alaw_i = 1'b0;
  logic        cfg_linear_i = 1'b0;
  logic        strap_gain_i = 1'b0;
  logic        strap_alaw_i = 1'b0;
  logic [7:0]  pcm_o;
  logic        pcm_valid_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  tx_pcm_fmt u_dut (.*);

  // {strap, strap_gain, strap_alaw, gain[7:0], alaw, linear, sample[15:0]}
  localparam int NV = 14;
  localparam logic [28:0] VEC [NV] = '{
    {3'b000, 8'hFF, 1'b0, 1'b0, 16'h03E8},
    {3'b000, 8'hFF, 1'b1, 1'b0, 16'hFC18},
    {3'b000, 8'h80, 1'b0, 1'b0, 16'h4E20},
    {3'b000, 8'h01, 1'b1, 1'b0, 16'h8000},
    {3'b000, 8'hC0, 1'b0, 1'b1, 16'hCFC7},
    {3'b000, 8'hFF, 1'b0, 1'b1, 16'h7FFF},
    {3'b000, 8'h37, 1'b0, 1'b0, 16'hFFFB},
    {3'b000, 8'hFF, 1'b1, 1'b0, 16'h001F},
    {3'b000, 8'h10, 1'b1, 1'b1, 16'h1000},
    {3'b110, 8'h00, 1'b1, 1'b1, 16'hB1E0},
    {3'b101, 8'h00, 1'b0, 1'b0, 16'h3A98},
    {3'b100, 8'hFF, 1'b1, 1'b1, 16'h8000},
    {3'b000, 8'hFF, 1'b0, 1'b0, 16'h8000},
    {3'b000, 8'hAA, 1'b1, 1'b0, 16'h012C}
  };

  function automatic int ref_scale(int s, int code);
    if (code == 0) return 0;
    return (s * (1036 + 12 * code)) >>> 12;
  endfunction

  function automatic int ref_mu(int x);
    int sgn, mag, e, mant;
    sgn = (x < 0) ? 1 : 0;
    mag = (x < 0) ? -x : x;
    if (mag > 32635) mag = 32635;
    mag = mag + 132;
    e = 7;
    while (e > 0 && mag < (1 << (e + 7))) e--;
    mant = (mag >> (e + 3)) & 15;
    return (~((sgn << 7) | (e << 4) | mant)) & 255;
  endfunction

  function automatic int ref_a(int x);
    int t, m, p, e, mant;
    t = x >>> 3;
    p = (t >= 0) ? 1 : 0;
    m = (t >= 0) ? t : -t - 1;
    e = 7;
    while (e > 0 && m < (16 << e)) e--;
    mant = (m >> ((e == 0) ? 1 : e)) & 15;
    return ((p << 7) | (e << 4) | mant) ^ 8'h55;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic load(bit st, bit sg, bit sa, logic [7:0] g, bit al, bit ln, logic [15:0] s);
    @(negedge clk_i);
    strap_mode_i = st; strap_gain_i = sg; strap_alaw_i = sa;
    cfg_gain_i = g; cfg_alaw_i = al; cfg_linear_i = ln;
    sample_i = s; sample_valid_i = 1'b1;
    @(negedge clk_i);
    sample_valid_i = 1'b0;
  endtask

  task automatic slot_read(output int b, output int v);
    slot_i = 1'b1;
    @(negedge clk_i);
    slot_i = 1'b0;
    b = int'(pcm_o);
    v = int'(pcm_valid_o);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int b, v, b2, v2;
    repeat (3) @(negedge clk_i);
    check("R1 reset pcm", int'(pcm_o), 0);
    check("R1 reset valid", int'(pcm_valid_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R1 idle after release", int'(pcm_valid_o), 0);

    for (int i = 0; i < NV; i++) begin
      logic [28:0] vv;
      bit st, ln, al;
      int g, sc, exp_w;
      string tag;
      vv = VEC[i];
      st = vv[28];
      g  = st ? (vv[27] ? 255 : 143) : int'(vv[25:18]);
      al = st ? vv[26] : vv[17];
      ln = st ? 1'b0 : vv[16];
      load(vv[28], vv[27], vv[26], vv[25:18], vv[17], vv[16], vv[15:0]);
      sc = ref_scale(int'($signed(vv[15:0])), g);
      if (st) tag = ln ? "R10" : (vv[27] ? "R9 R10" : "R9");
      else tag = ln ? "R7 R2" : (al ? "R6 R2" : "R5 R2");
      slot_read(b, v);
      check({tag, " valid"}, v, 1);
      if (ln) begin
        exp_w = sc & 16'hFFFF;
        check({tag, " high byte"}, b, exp_w >> 8);
        slot_read(b2, v2);
        check({tag, " low byte"}, b2, exp_w & 255);
      end else begin
        check({tag, " code"}, b, al ? ref_a(sc) : ref_mu(sc));
      end
    end

    // R3 mute in each law
    load(0, 0, 0, 8'h00, 0, 0, 16'h4000);
    slot_read(b, v); check("R3 mute ulaw", b, 8'hFF);
    load(0, 0, 0, 8'h00, 1, 0, 16'hC000);
    slot_read(b, v); check("R3 mute alaw", b, 8'hD5);
    load(0, 0, 0, 8'h00, 0, 1, 16'h7FFF);
    slot_read(b, v); check("R3 mute linear hi", b, 0);
    slot_read(b, v); check("R3 mute linear lo", b, 0);

    // R2 unity gain, R4 linear overrides law bit
    load(0, 0, 0, 8'hFF, 1, 1, 16'h1234);
    slot_read(b, v); check("R2 R4 unity hi", b, 8'h12);
    slot_read(b, v); check("R2 R4 unity lo", b, 8'h34);

    // R5/R6 full-scale literals, R4 law selection
    load(0, 0, 0, 8'hFF, 0, 0, 16'h7FFF);
    slot_read(b, v); check("R5 R4 ulaw full scale", b, 8'h80);
    load(0, 0, 0, 8'hFF, 1, 0, 16'h7FFF);
    slot_read(b, v); check("R6 R4 alaw full scale", b, 8'hAA);

    // R8 repeated slots carry the same code
    load(0, 0, 0, 8'hFF, 1, 0, 16'h0000);
    slot_read(b, v); check("R8 first slot", b, 8'hD5);
    slot_read(b, v); check("R8 second slot", b, 8'hD5);
    @(negedge clk_i);
    check("R11 no slot no valid", int'(pcm_valid_o), 0);

    // R7 alternation and restart on new sample
    load(0, 0, 0, 8'hFF, 0, 1, 16'hA55A);
    slot_read(b, v); check("R7 hi", b, 8'hA5);
    slot_read(b, v); check("R7 lo", b, 8'h5A);
    slot_read(b, v); check("R7 third slot hi again", b, 8'hA5);
    load(0, 0, 0, 8'hFF, 0, 1, 16'h3C96);
    slot_read(b, v); check("R7 restart hi", b, 8'h3C);

    // R9 strap ignores cfg mute, R10 strap ignores linear
    load(1, 1, 0, 8'h00, 1, 1, 16'h0000);
    slot_read(b, v); check("R9 R10 strap ulaw idle", b, 8'hFF);
    check("R11 valid with slot", v, 1);
    @(negedge clk_i);
    check("R11 valid drops", int'(pcm_valid_o), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule